// File: doc/BRIEF.md
# Event-Capturing Interval Timer

A 32-bit interval timer for system use. Software programs it through a small register bus. It counts ticks from one of four tick sources. Each source reaches the block as a one-cycle enable, and a two-bit field picks which source is used. The counter can count up or down. In free-running mode it wraps across the full 32-bit range. In periodic mode it reloads from a software-written load value. Each wrap or reload is an overflow.

An 8-bit postscaler counts overflows. A compare flag is raised when the programmed number of overflows has elapsed. The single interrupt output is driven either by every overflow or only by postscaler matches. A capture register takes a snapshot of the counter when a selected event line pulses, so software can timestamp external or internal events.

Bus access takes one cycle. A write is accepted on the clock edge where `bus_we` is high. Read data is registered and appears one cycle after the address is presented. Word addresses are: 0 load, 1 counter value (read-only), 2 control, 3 clear (write-only), 4 capture (read-only). Any other address reads 0.

Top module: `evt_timer`

## Requirements
- R1: After reset the control word reads 0x01000000, and the counter, load and capture registers read 0 and `irq` is low.
- R2: In free-running down mode (control bit 8 = 0, bit 6 = 0), a tick with the counter at 0 sets it to 0xFFFFFFFF and counts as an overflow. Any other tick decrements it.
- R3: In free-running up mode (bit 8 = 1, bit 6 = 0), a tick with the counter at 0xFFFFFFFF sets it to 0 and counts as an overflow. Any other tick increments it.
- R4: In periodic mode (bit 6 = 1), counting down, a tick at 0 reloads the load value. Counting up, a tick with the counter equal to the load value sets it to 0. Both are overflows.
- R5: The counter changes only on a tick. A tick is `tick_en[sel]` high while enable bit 7 is set, where sel is control bits 10:9. Enables of the other sources have no effect.
- R6: A write to the load address sets both the load register and the counter to the written value.
- R7: Control bits 31:24 set the postscaler target, and a written 0 becomes 1. Reading them returns the overflows still remaining before a match. This count is reloaded to the target on every control write.
- R8: With postscaler enable (bit 23) set, the overflow that brings the remaining count to its end sets the compare flag (bit 19, read-only) and reloads the remaining count to the target.
- R9: With source bit 18 clear, every overflow sets `irq`. With it set, only a postscaler match sets `irq`. `irq` stays high until cleared.
- R10: Any write to the clear address drops `irq` and the compare flag, unless a new setting condition occurs in the same cycle.
- R11: With capture enable (bit 17) set, a high level on `evt_in[n]` in a cycle copies the counter into the capture register. n is control bits 16:12. Other event lines, or a cleared enable, leave the capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the address |
| tick_en | input | 4 | Per-source tick enables |
| evt_in | input | NUM_EVT | Capture event lines |
| irq | output | 1 | Interrupt, level, held until cleared |

## Verification
A wrong counter step or reload shows up at the value address one read later. The interrupt line also rises on the wrong tick, in the same cycle as the faulty overflow. A postscaler fault stays hidden until the programmed number of overflows has passed. The remaining-count field exposes it earlier, so the bench reads that field in the middle of a sequence and again at the match. Capture errors appear only when the capture register is read back after an event, including events that must be ignored.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 8;
  localparam int SEL_W  = 5;

  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_VALUE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;

  typedef struct packed {
    logic             ps_en;
    logic             irq_src;
    logic             cap_en;
    logic [SEL_W-1:0] cap_sel;
    logic [1:0]       clk_sel;
    logic             up;
    logic             run;
    logic             periodic;
  } ctrl_t;
endpackage

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         up,
  input  logic         periodic,
  input  logic         ld_we,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] load_q;
  logic [W-1:0] nxt;

  always_comb begin
    ovf = 1'b0;
    nxt = cnt;
    if (up) begin
      if (periodic ? (cnt == load_q) : (cnt == ALL1)) begin
        ovf = tick;
        nxt = '0;
      end else begin
        nxt = cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        ovf = tick;
        nxt = periodic ? load_q : ALL1;
      end else begin
        nxt = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      load_q <= '0;
    end else if (ld_we) begin
      cnt    <= ld_val;
      load_q <= ld_val;
    end else if (tick) begin
      cnt <= nxt;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_we) |=> $stable(cnt));
  assert_down_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_we && !up && !periodic && cnt == '0) |=> (cnt == ALL1));
  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_we && up && !periodic && cnt == ALL1) |=> (cnt == '0));
endmodule

// File: rtl/evt_timer_post.sv
module evt_timer_post #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [PW-1:0] tgt_in,
  input  logic          en,
  input  logic          ovf,
  output logic [PW-1:0] remain,
  output logic          hit
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] tgt_q;
  logic [PW-1:0] tgt_fix;

  assign tgt_fix = (tgt_in == '0) ? ONE : tgt_in;
  assign hit     = en && ovf && !wr && (remain == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= ONE;
      remain <= ONE;
    end else if (wr) begin
      tgt_q  <= tgt_fix;
      remain <= tgt_fix;
    end else if (en && ovf) begin
      remain <= (remain == ONE) ? tgt_q : remain - 1'b1;
    end
  end

  assert_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    remain != '0);
  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    hit |=> (remain == tgt_q));
endmodule

// File: rtl/evt_timer_capt.sv
module evt_timer_capt #(
  parameter int W     = 32,
  parameter int NE    = 18,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [NE-1:0]    evt,
  input  logic [W-1:0]     cnt,
  output logic [W-1:0]     cap
);
  logic fire;

  always_comb begin
    fire = 1'b0;
    for (int i = 0; i < NE; i++)
      if (sel == SEL_W'(i) && evt[i]) fire = en;
  end

  always_ff @(posedge clk) begin
    if (rst)       cap <= '0;
    else if (fire) cap <= cnt;
  end

  assert_cap_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cap));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int NUM_EVT = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        tick_en,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic              irq
);
  ctrl_t             ctrl;
  logic              flag;
  logic              tick, ovf, hit, set_irq;
  logic              wr_ctrl, wr_load, wr_clr;
  logic [DATA_W-1:0] cnt, cap;
  logic [PS_W-1:0]   remain;

  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign wr_load = bus_we && bus_addr == A_LOAD;
  assign wr_clr  = bus_we && bus_addr == A_CLEAR;
  assign tick    = ctrl.run && tick_en[ctrl.clk_sel];
  assign set_irq = ctrl.irq_src ? hit : ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.ps_en    <= bus_wdata[23];
      ctrl.irq_src  <= bus_wdata[18];
      ctrl.cap_en   <= bus_wdata[17];
      ctrl.cap_sel  <= bus_wdata[16:12];
      ctrl.clk_sel  <= bus_wdata[10:9];
      ctrl.up       <= bus_wdata[8];
      ctrl.run      <= bus_wdata[7];
      ctrl.periodic <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (set_irq)     irq <= 1'b1;
      else if (wr_clr) irq <= 1'b0;
      if (hit)         flag <= 1'b1;
      else if (wr_clr) flag <= 1'b0;
    end
  end

  evt_timer_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .up(ctrl.up), .periodic(ctrl.periodic),
    .ld_we(wr_load), .ld_val(bus_wdata), .cnt(cnt), .ovf(ovf)
  );

  evt_timer_post #(.PW(PS_W)) u_post (
    .clk(clk), .rst(rst), .wr(wr_ctrl), .tgt_in(bus_wdata[31:24]),
    .en(ctrl.ps_en), .ovf(ovf), .remain(remain), .hit(hit)
  );

  evt_timer_capt #(.W(DATA_W), .NE(NUM_EVT), .SEL_W(SEL_W)) u_capt (
    .clk(clk), .rst(rst), .en(ctrl.cap_en), .sel(ctrl.cap_sel),
    .evt(evt_in), .cnt(cnt), .cap(cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_LOAD:  bus_rdata <= u_core.load_q;
        A_VALUE: bus_rdata <= cnt;
        A_CTRL:  bus_rdata <= {remain, ctrl.ps_en, 3'b000, flag, ctrl.irq_src,
                               ctrl.cap_en, ctrl.cap_sel, 1'b0, ctrl.clk_sel,
                               ctrl.up, ctrl.run, ctrl.periodic, 6'b0};
        A_CAPT:  bus_rdata <= cap;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !set_irq) |=> !irq);
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_clr) |=> irq);
  assert_flag_src_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(ctrl.ps_en));
endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
  localparam int NE = 18;
  logic        clk = 1'b0, rst = 1'b1, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic [3:0]  tick_en = '0;
  logic [NE-1:0] evt = '0;
  logic        irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  evt_timer #(.NUM_EVT(NE)) u_dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .tick_en(tick_en), .evt_in(evt), .irq(irq)
  );

  // vector columns: up, periodic, load, ticks, expected value, expected irq
  localparam int NV = 6;
  localparam logic        V_UP  [NV] = '{0, 0, 0, 1, 1, 1};
  localparam logic        V_PER [NV] = '{0, 0, 1, 1, 0, 0};
  localparam logic [31:0] V_LD  [NV] = '{32'd10, 32'd2, 32'd3, 32'd3, 32'hFFFF_FFFE, 32'd5};
  localparam int          V_N   [NV] = '{4, 3, 5, 5, 3, 2};
  localparam logic [31:0] V_EXP [NV] = '{32'd6, 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd1, 32'd7};
  localparam logic        V_IRQ [NV] = '{0, 1, 1, 1, 1, 0};

  function automatic logic [31:0] mk(input logic [7:0] pv, input logic pe, src, ce,
      input logic [4:0] sel, input logic [1:0] cs, input logic up, run, per);
    return {pv, pe, 3'b0, 1'b0, src, ce, sel, 1'b0, cs, up, run, per, 6'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(input int n, input int src);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 4'(1 << src);
      @(negedge clk); tick_en = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd2, rv); chk("R1 ctrl", rv, 32'h0100_0000);
    rd(3'd1, rv); chk("R1 value", rv, 32'd0);
    rd(3'd4, rv); chk("R1 capture", rv, 32'd0);
    rd(3'd0, rv); chk("R1 load", rv, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);

    // R2 R3 R4 R6 R9: vector table
    for (int v = 0; v < NV; v++) begin
      wr(3'd2, 32'd0);
      wr(3'd0, V_LD[v]);
      rd(3'd1, rv); chk("R6 load sets value", rv, V_LD[v]);
      wr(3'd3, 32'd0);
      wr(3'd2, mk(8'd1, 0, 0, 0, 5'd0, 2'd2, V_UP[v], 1, V_PER[v]));
      ticks(V_N[v], 2);
      rd(3'd1, rv); chk("R2/R3/R4 value", rv, V_EXP[v]);
      chk("R9 overflow irq", {31'b0, irq}, {31'b0, V_IRQ[v]});
    end

    // R5: other source and disabled timer have no effect
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd50);
    wr(3'd2, mk(8'd1, 0, 0, 0, 5'd0, 2'd2, 0, 1, 0));
    ticks(3, 0); ticks(2, 3);
    rd(3'd1, rv); chk("R5 unselected source", rv, 32'd50);
    ticks(2, 2);
    rd(3'd1, rv); chk("R5 selected source", rv, 32'd48);
    wr(3'd2, mk(8'd1, 0, 0, 0, 5'd0, 2'd2, 0, 0, 0));
    ticks(3, 2);
    rd(3'd1, rv); chk("R5 disabled", rv, 32'd48);

    // R7 R8 R9: postscaler target 3, one overflow every 2 ticks
    wr(3'd0, 32'd1);
    wr(3'd3, 32'd0);
    wr(3'd2, mk(8'd3, 1, 1, 0, 5'd0, 2'd2, 0, 1, 1));
    rd(3'd2, rv); chk("R7 remaining after write", {24'b0, rv[31:24]}, 32'd3);
    ticks(4, 2);
    rd(3'd2, rv); chk("R7 remaining mid", {24'b0, rv[31:24]}, 32'd1);
    chk("R8 flag before match", {31'b0, rv[19]}, 32'd0);
    chk("R9 no irq before match", {31'b0, irq}, 32'd0);
    ticks(2, 2);
    rd(3'd2, rv); chk("R8 remaining reloaded", {24'b0, rv[31:24]}, 32'd3);
    chk("R8 flag set", {31'b0, rv[19]}, 32'd1);
    chk("R9 postscaler irq", {31'b0, irq}, 32'd1);

    // R10 clear
    wr(3'd3, 32'd0);
    rd(3'd2, rv); chk("R10 flag cleared", {31'b0, rv[19]}, 32'd0);
    chk("R10 irq cleared", {31'b0, irq}, 32'd0);

    // R9 direct source with postscaler still counting
    wr(3'd2, mk(8'd3, 1, 0, 0, 5'd0, 2'd2, 0, 1, 1));
    ticks(2, 2);
    chk("R9 direct irq", {31'b0, irq}, 32'd1);
    rd(3'd2, rv); chk("R9 no flag yet", {31'b0, rv[19]}, 32'd0);
    chk("R7 remaining after one", {24'b0, rv[31:24]}, 32'd2);

    // R7 zero target reads as one
    wr(3'd2, mk(8'd0, 0, 0, 0, 5'd0, 2'd2, 0, 0, 0));
    rd(3'd2, rv); chk("R7 zero target", {24'b0, rv[31:24]}, 32'd1);

    // R11 capture
    wr(3'd0, 32'd100);
    wr(3'd2, mk(8'd1, 0, 0, 1, 5'd5, 2'd2, 0, 1, 0));
    ticks(3, 2);
    @(negedge clk); evt[5] = 1'b1;
    @(negedge clk); evt[5] = 1'b0;
    rd(3'd4, rv); chk("R11 capture selected", rv, 32'd97);
    ticks(2, 2);
    @(negedge clk); evt[4] = 1'b1;
    @(negedge clk); evt[4] = 1'b0;
    rd(3'd4, rv); chk("R11 other event ignored", rv, 32'd97);
    wr(3'd2, mk(8'd1, 0, 0, 0, 5'd5, 2'd2, 0, 1, 0));
    @(negedge clk); evt[5] = 1'b1;
    @(negedge clk); evt[5] = 1'b0;
    rd(3'd4, rv); chk("R11 capture disabled", rv, 32'd97);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule